// File: doc/BRIEF.md
# DMA Trigger Select and Channel Arbiter

This block is the shared request front end of a multi-channel DMA controller (three channels by default). Each channel picks its start condition from sixteen candidates with a 4-bit code. The candidates are a software request bit, thirteen peripheral event lines, the interrupt flag of the neighbouring channel (for chaining), and an external pin. The selected line is watched either for a rising edge, which is latched until served, or for a high level, which is looked at afresh every cycle.

All channel requests meet in one arbiter. It issues at most one single-cycle grant per clock to a transfer engine, which is not part of this block. Priority is either fixed, with the lowest channel number first, or a least-recently-served order. In that order the channel just served drops to the back and the others keep their relative order. An option holds every grant back until the processor signals an instruction fetch. The block also keeps the per-channel completion flags and presents an interrupt vector for the lowest-numbered pending flag. A vector read clears that flag.

Top module: `dta_trig_arb`

## Requirements
- R1: The select code for channel c sits at `trig_sel[4c+3:4c]`. Code 0 selects `soft_req[c]`. Codes 1 to 13 select `periph_trig[code-1]`. Code 14 selects the flag of channel c-1, and channel 0 takes the flag of the last channel. Code 15 selects `ext_trig`.
- R2: With `level_mode[c]`=0, a rising edge of the selected line makes a pending request. That request stays pending until it is granted. Without contention and deferral, the grant is high in the cycle after the cycle where the line first reads high. One edge yields exactly one grant.
- R3: With `level_mode[c]`=1, a channel requests only in cycles where its selected line is high. A level that falls before it is granted leaves no request behind.
- R4: `grant` is registered, has at most one bit set, and is a one-cycle pulse for each request served.
- R5: With `rr_en`=0, channel 0 beats channel 1, and channel 1 beats channel 2, in every cycle.
- R6: With `rr_en`=1, the channel just granted moves to the lowest priority and the others keep their order. The order returns to 0,1,2 while `rr_en` is 0.
- R7: With `fetch_defer`=1, a grant is issued only in the cycle after a cycle with `fetch_strobe` high. Edge requests stay pending while they wait.
- R8: `vec_out` is 00h when no flag is set. Otherwise it is 02h, 04h or 06h for the lowest-numbered set flag among channels 0, 1 and 2. Codes 08h to 0Eh never appear.
- R9: A clock edge with `vec_read` high clears the flag that `vec_out` reports. A `done_set` on that same channel in that same cycle wins, and the flag stays set.
- R10: Synchronous reset clears pending requests, flags and the priority order. `grant` and `vec_out` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_sel | input | NCH*4 | Per-channel 4-bit trigger select codes |
| level_mode | input | NCH | 1 = level-sensitive, 0 = rising-edge |
| soft_req | input | NCH | Software request per channel |
| periph_trig | input | 13 | Peripheral event lines for codes 1..13 |
| ext_trig | input | 1 | External trigger pin |
| done_set | input | NCH | Completion pulses that set the channel flags |
| rr_en | input | 1 | 1 = least-recently-served priority |
| fetch_defer | input | 1 | 1 = hold grants until an instruction fetch |
| fetch_strobe | input | 1 | Instruction fetch indication |
| vec_read | input | 1 | Vector read; clears the reported flag |
| grant | output | NCH | One-hot grant pulse to the transfer engines |
| irq_flags | output | NCH | Channel completion flags |
| vec_out | output | 8 | Interrupt vector of the lowest pending flag |

## Verification
Two collisions are provoked on purpose. In the first, a vector read and a new completion pulse for the same channel land on one clock edge. The bench expects the flag to survive and the vector to keep reporting that channel. In the second, several channels become ready in one cycle under each priority mode. The bench predicts the exact grant sequence. Its round-robin case is built so that a plain rotating pointer would grant a different channel than the move-to-back order.

// File: rtl/dta_pkg.sv
package dta_pkg;

    localparam int SEL_W = 4;
    localparam int NSRC  = 1 << SEL_W;
    localparam int NPER  = NSRC - 3;
    localparam int IDX_W = 3;
    localparam int VEC_W = 8;

    localparam logic [SEL_W-1:0] CODE_SOFT  = '0;
    localparam logic [SEL_W-1:0] CODE_EXT   = '1;
    localparam logic [SEL_W-1:0] CODE_CHAIN = CODE_EXT - 1'b1;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } pick_t;

    function automatic logic [VEC_W-1:0] vec_encode(pick_t p);
        logic [IDX_W-1:0] n;
        n = p.idx + 1'b1;
        if (!p.valid) return '0;
        return {{(VEC_W-IDX_W-1){1'b0}}, n, 1'b0};
    endfunction

endpackage

// File: rtl/dta_trig_sel.sv
module dta_trig_sel
    import dta_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    input  logic             level,
    input  logic             sw,
    input  logic [NPER-1:0]  per,
    input  logic             chain,
    input  logic             ext,
    input  logic             take,
    output logic             req
);
    logic             src;
    logic             prev_q;
    logic             pend_q;
    logic             rise;
    logic [SEL_W-1:0] pidx;

    always_comb begin
        pidx = sel - 1'b1;
        if (sel == CODE_SOFT)       src = sw;
        else if (sel == CODE_CHAIN) src = chain;
        else if (sel == CODE_EXT)   src = ext;
        else                        src = per[pidx];
    end

    assign rise = src & ~prev_q;
    assign req  = level ? src : (pend_q | rise);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= src;
            pend_q <= level ? 1'b0 : ((pend_q | rise) & ~take);
        end
    end
endmodule

// File: rtl/dta_prio_arb.sv
module dta_prio_arb
    import dta_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] req,
    input  logic           rr_en,
    input  logic           eligible,
    output logic [NCH-1:0] take,
    output logic [NCH-1:0] grant
);
    logic [IDX_W-1:0] order_q [NCH];
    logic [IDX_W-1:0] eff     [NCH];
    logic [IDX_W-1:0] nxt     [NCH];
    pick_t            pick;
    int               pos;

    always_comb begin
        for (int k = 0; k < NCH; k++)
            eff[k] = rr_en ? order_q[k] : IDX_W'(k);
        pick = '0;
        for (int k = 0; k < NCH; k++)
            if (!pick.valid && req[eff[k]]) pick = '{valid: 1'b1, idx: eff[k]};
        take = '0;
        if (eligible && pick.valid) take[pick.idx] = 1'b1;
    end

    always_comb begin
        pos = 0;
        for (int k = 0; k < NCH; k++)
            if (eff[k] == pick.idx) pos = k;
        for (int k = 0; k < NCH; k++) begin
            if (k < pos)          nxt[k] = eff[k];
            else if (k < NCH - 1) nxt[k] = eff[(k + 1) % NCH];
            else                  nxt[k] = pick.idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grant <= '0;
            for (int k = 0; k < NCH; k++) order_q[k] <= IDX_W'(k);
        end else begin
            grant <= take;
            for (int k = 0; k < NCH; k++) begin
                if (!rr_en)    order_q[k] <= IDX_W'(k);
                else if (|take) order_q[k] <= nxt[k];
                else           order_q[k] <= eff[k];
            end
        end
    end
endmodule

// File: rtl/dta_irq_vec.sv
module dta_irq_vec
    import dta_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH-1:0]   set,
    input  logic             rd,
    output logic [NCH-1:0]   flags,
    output logic [VEC_W-1:0] vec
);
    pick_t          pick;
    logic [NCH-1:0] clr;

    always_comb begin
        pick = '0;
        for (int c = NCH - 1; c >= 0; c--)
            if (flags[c]) pick = '{valid: 1'b1, idx: IDX_W'(c)};
        clr = '0;
        if (rd && pick.valid) clr[pick.idx] = 1'b1;
    end

    assign vec = vec_encode(pick);

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~clr) | set;
    end
endmodule

// File: rtl/dta_trig_arb.sv
module dta_trig_arb
    import dta_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NCH*SEL_W-1:0] trig_sel,
    input  logic [NCH-1:0]       level_mode,
    input  logic [NCH-1:0]       soft_req,
    input  logic [NPER-1:0]      periph_trig,
    input  logic                 ext_trig,
    input  logic [NCH-1:0]       done_set,
    input  logic                 rr_en,
    input  logic                 fetch_defer,
    input  logic                 fetch_strobe,
    input  logic                 vec_read,
    output logic [NCH-1:0]       grant,
    output logic [NCH-1:0]       irq_flags,
    output logic [VEC_W-1:0]     vec_out
);
    logic [NCH-1:0] req_w;
    logic [NCH-1:0] take_w;
    logic           eligible;

    assign eligible = ~fetch_defer | fetch_strobe;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dta_trig_sel u_sel (
            .clk   (clk),
            .rst   (rst),
            .sel   (trig_sel[c*SEL_W +: SEL_W]),
            .level (level_mode[c]),
            .sw    (soft_req[c]),
            .per   (periph_trig),
            .chain (irq_flags[(c + NCH - 1) % NCH]),
            .ext   (ext_trig),
            .take  (take_w[c]),
            .req   (req_w[c])
        );
    end

    dta_prio_arb #(.NCH(NCH)) u_arb (
        .clk      (clk),
        .rst      (rst),
        .req      (req_w),
        .rr_en    (rr_en),
        .eligible (eligible),
        .take     (take_w),
        .grant    (grant)
    );

    dta_irq_vec #(.NCH(NCH)) u_vec (
        .clk   (clk),
        .rst   (rst),
        .set   (done_set),
        .rd    (vec_read),
        .flags (irq_flags),
        .vec   (vec_out)
    );
endmodule

// File: rtl/dta_arb_checker.sv
module dta_arb_checker #(
    parameter int NCH = 3
) (
    input logic           clk,
    input logic           rst,
    input logic           rr_en,
    input logic           fetch_defer,
    input logic           fetch_strobe,
    input logic           vec_read,
    input logic [NCH-1:0] done_set,
    input logic [NCH-1:0] req_w,
    input logic [NCH-1:0] take_w,
    input logic [NCH-1:0] grant,
    input logic [NCH-1:0] irq_flags,
    input logic [7:0]     vec_out
);
    assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    assert_grant_has_req_R4: assert property (@(posedge clk) disable iff (rst)
        (|take_w) |-> ((take_w & req_w) == take_w));

    assert_fixed_order_R5: assert property (@(posedge clk) disable iff (rst)
        (!rr_en && |take_w) |-> (((take_w - 1'b1) & req_w) == '0));

    assert_defer_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (fetch_defer && !fetch_strobe) |=> (grant == '0));

    assert_vec_even_R8: assert property (@(posedge clk) disable iff (rst)
        (vec_out[0] == 1'b0) && (vec_out <= 8'(2 * NCH)));

    assert_vec_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (vec_out == 8'h00) == (irq_flags == '0));

    assert_read_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (vec_read && vec_out == 8'h02 && !done_set[0]) |=> !irq_flags[0]);

    assert_reset_quiet_R10: assert property (@(posedge clk)
        rst |=> (grant == '0 && irq_flags == '0));
endmodule

bind dta_trig_arb dta_arb_checker #(.NCH(NCH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rr_en        (rr_en),
    .fetch_defer  (fetch_defer),
    .fetch_strobe (fetch_strobe),
    .vec_read     (vec_read),
    .done_set     (done_set),
    .req_w        (req_w),
    .take_w       (take_w),
    .grant        (grant),
    .irq_flags    (irq_flags),
    .vec_out      (vec_out)
);

// File: tb/dta_trig_arb_tb.sv
`timescale 1ns/1ps
module dta_trig_arb_tb;
    localparam int NCH = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [11:0]   trig_sel = '0;
    logic [2:0]    level_mode = '0;
    logic [2:0]    soft_req = '0;
    logic [12:0]   periph_trig = '0;
    logic          ext_trig = 1'b0;
    logic [2:0]    done_set = '0;
    logic          rr_en = 1'b0;
    logic          fetch_defer = 1'b0;
    logic          fetch_strobe = 1'b0;
    logic          vec_read = 1'b0;
    logic [2:0]    grant;
    logic [2:0]    irq_flags;
    logic [7:0]    vec_out;

    int errs = 0;
    int checks = 0;
    int cyc_n = 0;

    typedef struct {
        int         due;
        logic [2:0] g;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    dta_trig_arb #(.NCH(NCH)) u_dut (
        .clk(clk), .rst(rst), .trig_sel(trig_sel), .level_mode(level_mode),
        .soft_req(soft_req), .periph_trig(periph_trig), .ext_trig(ext_trig),
        .done_set(done_set), .rr_en(rr_en), .fetch_defer(fetch_defer),
        .fetch_strobe(fetch_strobe), .vec_read(vec_read), .grant(grant),
        .irq_flags(irq_flags), .vec_out(vec_out)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc_n <= cyc_n + 1;

    task automatic chk(input bit ok, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // driver side: grant expected after the coming clock edge
    task automatic expect_g(input logic [2:0] g, input string tag);
        sb_q.push_back('{due: cyc_n + 1, g: g, tag: tag});
    endtask

    // monitor side
    always @(negedge clk) begin
        exp_t it;
        while (sb_q.size() > 0 && sb_q[0].due <= cyc_n) begin
            it = sb_q.pop_front();
            chk(grant == it.g && it.due == cyc_n, it.tag, grant, it.g);
        end
    end

    task automatic set_sel(input int c, input logic [3:0] code);
        trig_sel[c*4 +: 4] = code;
    endtask

    initial begin
        #2_000_000;
        chk(1'b0, "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) tick();
        chk(grant == 3'b000, "R10 reset grant", grant, 0);
        chk(vec_out == 8'h00, "R10 reset vector", vec_out, 0);
        rst = 1'b0;
        tick();

        // R1/R2 software code 0, single pulse -> single grant
        soft_req = 3'b001; expect_g(3'b001, "R1 soft code grant"); tick();
        soft_req = 3'b000; expect_g(3'b000, "R2 one grant per edge"); tick();

        // R1 peripheral codes
        set_sel(1, 4'd5); tick();
        periph_trig[3] = 1'b1; expect_g(3'b000, "R1 unselected line ignored"); tick();
        periph_trig = '0; tick();
        periph_trig[4] = 1'b1; expect_g(3'b010, "R1 code5 grant"); tick();
        expect_g(3'b000, "R2 held level no new edge"); tick();
        periph_trig = '0;
        set_sel(1, 4'd13); tick();
        periph_trig[12] = 1'b1; expect_g(3'b010, "R1 code13 grant"); tick();
        periph_trig = '0; tick();

        // R1 external code 15
        set_sel(2, 4'd15);
        ext_trig = 1'b1; expect_g(3'b100, "R1 external grant"); tick();
        ext_trig = 1'b0; expect_g(3'b000, "R1 external done"); tick();

        // R1 chaining code 14 from channel 0 flag
        set_sel(1, 4'd14);
        done_set = 3'b001; expect_g(3'b000, "R1 chain before flag"); tick();
        done_set = 3'b000; expect_g(3'b010, "R1 chain grant"); tick();
        chk(vec_out == 8'h02, "R8 vector ch0", vec_out, 8'h02);
        vec_read = 1'b1; tick();
        vec_read = 1'b0;
        chk(vec_out == 8'h00, "R9 read clears", vec_out, 0);
        trig_sel = '0; tick();

        // R2/R5 simultaneous edges, fixed priority, pending held
        soft_req = 3'b111; expect_g(3'b001, "R5 fixed first ch0"); tick();
        soft_req = 3'b000; expect_g(3'b010, "R2 pending ch1"); tick();
        expect_g(3'b100, "R2 pending ch2"); tick();
        expect_g(3'b000, "R4 all served"); tick();

        // R3 level mode
        level_mode = 3'b011;
        soft_req = 3'b011; expect_g(3'b001, "R3 level ch0"); tick();
        expect_g(3'b001, "R3 level ch0 again"); tick();
        soft_req = 3'b000; expect_g(3'b000, "R3 level dropped"); tick();

        // R6 round robin, move-to-back order
        level_mode = 3'b111; rr_en = 1'b1;
        soft_req = 3'b010; expect_g(3'b010, "R6 serve ch1"); tick();
        soft_req = 3'b101; expect_g(3'b001, "R6 ch1 moved to back"); tick();
        expect_g(3'b100, "R6 ch0 moved back"); tick();
        soft_req = 3'b111; expect_g(3'b010, "R6 ch1 turn"); tick();
        expect_g(3'b001, "R6 ch0 turn"); tick();
        soft_req = 3'b000; rr_en = 1'b0; expect_g(3'b000, "R6 idle"); tick();
        soft_req = 3'b111; expect_g(3'b001, "R5 fixed no rotation"); tick();
        expect_g(3'b001, "R5 fixed still ch0"); tick();
        soft_req = 3'b000; level_mode = 3'b000; expect_g(3'b000, "R3 levels off"); tick();

        // R7 deferred to instruction fetch
        fetch_defer = 1'b1;
        soft_req = 3'b001; expect_g(3'b000, "R7 wait fetch"); tick();
        soft_req = 3'b000; expect_g(3'b000, "R7 still waiting"); tick();
        expect_g(3'b000, "R7 still waiting 2"); tick();
        fetch_strobe = 1'b1; expect_g(3'b001, "R7 grant on fetch"); tick();
        fetch_strobe = 1'b0; expect_g(3'b000, "R7 after fetch"); tick();
        fetch_defer = 1'b0;

        // R8/R9 vector
        done_set = 3'b110; tick();
        done_set = 3'b000;
        chk(vec_out == 8'h04, "R8 lowest flag ch1", vec_out, 8'h04);
        vec_read = 1'b1; tick();
        chk(vec_out == 8'h06, "R9 read then ch2", vec_out, 8'h06);
        done_set = 3'b100; tick();
        done_set = 3'b000;
        chk(vec_out == 8'h06 && irq_flags == 3'b100, "R9 set wins over read", vec_out, 8'h06);
        tick();
        chk(vec_out == 8'h00, "R8 none pending", vec_out, 0);
        done_set = 3'b011; tick();
        done_set = 3'b000;
        chk(vec_out == 8'h02, "R8 ch0 first", vec_out, 8'h02);
        tick();
        chk(vec_out == 8'h04, "R9 then ch1", vec_out, 8'h04);
        tick();
        vec_read = 1'b0;
        chk(vec_out == 8'h00 && irq_flags == 3'b000, "R9 all read", vec_out, 0);

        // R10 reset mid operation
        done_set = 3'b001; tick();
        done_set = 3'b000;
        rst = 1'b1; expect_g(3'b000, "R10 grant in reset"); tick();
        chk(vec_out == 8'h00 && irq_flags == 3'b000, "R10 flags cleared", vec_out, 0);
        rst = 1'b0;
        repeat (3) tick();
        chk(sb_q.size() == 0, "R4 scoreboard drained", sb_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule